// File: doc/BRIEF.md
# Auto-Baud Sample Tick Generator

This block learns the serial bit rate from a fixed synchronisation character sent at the start of every transaction. There is no programmable rate register. The only way to set the rate is to send that character. The character is 0x55, framed with a low start bit and a high stop bit and sent least significant bit first. On the idle-high line it shows five falling edges, two bit periods apart, spread over eight bit periods. The block counts system clocks from the first falling edge to the fifth. It checks each of the four gaps against a configured window of bit periods, then keeps the total span as a fixed-point period with seven fraction bits.

Once locked, the block emits a one-clock sample strobe sixteen times per bit period. It reloads an integer clock count for each strobe and carries the fractional remainder from strobe to strobe. Over one span the strobes therefore add up to the measured clock count exactly. Receive and transmit framing logic both use the same strobe. The framing logic pulses the restart input when a transaction ends. This drops the valid flag and re-arms the detector for the next synchronisation character.

Top module: `autobaud_gen`

## Requirements
- R1: After the synchronous active-high reset, `baud_valid_o` and `tick_o` are both 0.
- R2: The line idles high. After the first falling edge starts a measurement, four more falling edges complete it (the 0x55 character: start bit low, data least significant bit first). `baud_valid_o` rises on the clock edge two clocks after the edge at which `rxd_i` is first sampled low for the fifth fall. This holds with the default of two synchroniser stages. The span S is the clock count between the first and fifth detected falls.
- R3: Every gap between consecutive falling edges must lie in [2*MIN_BIT, 2*MAX_BIT] clocks. A fall that arrives too early discards the measurement, and the block waits for a fresh falling edge. `baud_valid_o` stays 0.
- R4: If no falling edge arrives within 2*MAX_BIT clocks of the previous one, the measurement is abandoned and `baud_valid_o` stays 0.
- R5: With lock on clock edge L, `tick_o` is high for exactly one clock after edge L + floor(k*S/128), for k = 1, 2, and so on. Every window of S clocks holds 128 strobes (16 per bit period). Strobe spacing is always floor(S/128) or ceil(S/128).
- R6: While `baud_valid_o` is high, activity on `rxd_i`, including a further synchronisation character, changes neither the flag nor the strobe timing.
- R7: A high `restart_i` sampled on a clock edge clears `baud_valid_o` and `tick_o` on that edge and re-arms the detector. It wins over a lock completing on the same edge.
- R8: `tick_o` is never high while `baud_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| restart_i | input | 1 | Drop the learned rate and wait for the next synchronisation character |
| tick_o | output | 1 | One-clock 16x oversampling strobe |
| baud_valid_o | output | 1 | A learned rate is held and strobes are running |

## Verification
A fall on the line becomes visible to the measurement logic two clocks after `rxd_i` is first sampled low. Lock therefore lands on the edge that follows that delay. The k-th strobe then appears on edge L + floor(k*S/128), and a restart takes effect on the very edge that samples it. The bench drives every input on the falling clock edge. It keeps a behavioural model that advances on each rising edge with exactly these delays, and compares both outputs with it at every falling edge. Separate checks count strobes over whole S-clock windows and measure their spacing, so the results do not depend on phase.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  // 16 strobes per bit times 8 bits in the measured span
  localparam int unsigned FRAC_BITS = 7;
  localparam int unsigned SPAN_FALLS = 5;

  typedef enum logic [1:0] {
    MS_HUNT    = 2'd0,
    MS_MEASURE = 2'd1,
    MS_LOCKED  = 2'd2
  } meter_state_e;
endpackage

// File: rtl/abg_edge_sync.sv
module abg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic fall_o
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[STAGES-1:0], rx_i};
  end

  assign fall_o = shreg[STAGES] & ~shreg[STAGES-1];
endmodule

// File: rtl/abg_synch_meter.sv
module abg_synch_meter
  import autobaud_pkg::*;
#(
  parameter int unsigned MIN_BIT = 16,
  parameter int unsigned MAX_BIT = 1024,
  parameter int unsigned CNT_W   = $clog2(2 * MAX_BIT + 2),
  parameter int unsigned TOT_W   = $clog2(8 * MAX_BIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             fall_i,
  output logic             lock_o,
  output logic [TOT_W-1:0] span_o
);
  localparam logic [CNT_W-1:0] GAP_LO = CNT_W'(2 * MIN_BIT);
  localparam logic [CNT_W-1:0] GAP_HI = CNT_W'(2 * MAX_BIT);
  localparam logic [2:0]       LAST_FALL = 3'(SPAN_FALLS - 1);

  meter_state_e     state;
  logic [CNT_W-1:0] gap_cnt;
  logic [2:0]       falls;
  logic [TOT_W-1:0] tot;
  logic             gap_ok;

  assign gap_ok = (gap_cnt >= GAP_LO) && (gap_cnt <= GAP_HI);
  assign span_o = tot + TOT_W'(gap_cnt);
  assign lock_o = (state == MS_MEASURE) && fall_i && gap_ok &&
                  (falls == LAST_FALL) && !restart_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      state   <= MS_HUNT;
      gap_cnt <= '0;
      falls   <= '0;
      tot     <= '0;
    end else begin
      case (state)
        MS_HUNT: begin
          if (fall_i) begin
            state   <= MS_MEASURE;
            gap_cnt <= CNT_W'(1);
            falls   <= 3'd1;
            tot     <= '0;
          end
        end
        MS_MEASURE: begin
          if (fall_i) begin
            if (!gap_ok) begin
              state <= MS_HUNT;
            end else begin
              tot     <= span_o;
              falls   <= falls + 3'd1;
              gap_cnt <= CNT_W'(1);
              if (falls == LAST_FALL) state <= MS_LOCKED;
            end
          end else if (gap_cnt > GAP_HI) begin
            state <= MS_HUNT;
          end else begin
            gap_cnt <= gap_cnt + CNT_W'(1);
          end
        end
        MS_LOCKED: state <= MS_LOCKED;
        default:   state <= MS_HUNT;
      endcase
    end
  end

  // R3: a lock only ever reports a span inside the configured window
  assert_span_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> (span_o >= TOT_W'(8 * MIN_BIT)) && (span_o <= TOT_W'(8 * MAX_BIT)));

  // R4: the gap counter is abandoned one clock past the longest legal gap
  assert_gap_timeout_R4: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= GAP_HI + CNT_W'(1));

  // R4: an overdue gap without a fall drops back to hunting
  assert_timeout_hunt_R4: assert property (@(posedge clk) disable iff (rst)
    (state == MS_MEASURE && !fall_i && gap_cnt > GAP_HI) |=> (state == MS_HUNT));
endmodule

// File: rtl/abg_tick_gen.sv
module abg_tick_gen
  import autobaud_pkg::*;
#(
  parameter int unsigned TOT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             lock_i,
  input  logic [TOT_W-1:0] span_i,
  output logic             tick_o,
  output logic             valid_o
);
  localparam int unsigned IW = TOT_W - FRAC_BITS;
  localparam int unsigned TW = IW + 1;

  logic [IW-1:0]        inc_int;
  logic [FRAC_BITS-1:0] inc_frac;
  logic [TW-1:0]        tcnt;
  logic [FRAC_BITS-1:0] facc;
  logic [FRAC_BITS:0]   fsum;

  assign fsum = {1'b0, facc} + {1'b0, inc_frac};

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      valid_o  <= 1'b0;
      tick_o   <= 1'b0;
      inc_int  <= '0;
      inc_frac <= '0;
      tcnt     <= '0;
      facc     <= '0;
    end else if (lock_i) begin
      valid_o  <= 1'b1;
      tick_o   <= 1'b0;
      inc_int  <= span_i[TOT_W-1:FRAC_BITS];
      inc_frac <= span_i[FRAC_BITS-1:0];
      tcnt     <= {1'b0, span_i[TOT_W-1:FRAC_BITS]};
      facc     <= span_i[FRAC_BITS-1:0];
    end else if (valid_o) begin
      if (tcnt == TW'(1)) begin
        tick_o <= 1'b1;
        tcnt   <= {1'b0, inc_int} + TW'(fsum[FRAC_BITS]);
        facc   <= fsum[FRAC_BITS-1:0];
      end else begin
        tick_o <= 1'b0;
        tcnt   <= tcnt - TW'(1);
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  // R8: no strobe without a held rate
  assert_tick_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> valid_o);

  // R7: restart clears both outputs on the edge that samples it
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !valid_o && !tick_o);

  // R6: the held rate never changes until a restart
  assert_rate_held_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !restart_i) |=> valid_o && $stable(inc_int) && $stable(inc_frac));

  // R5: a running countdown never reaches zero
  assert_countdown_live_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (tcnt != '0));

  // R2: a lock always loads a period of at least one clock per strobe
  assert_lock_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    lock_i |-> (span_i[TOT_W-1:FRAC_BITS] != '0));
endmodule

// File: rtl/autobaud_gen.sv
module autobaud_gen
  import autobaud_pkg::*;
#(
  parameter int unsigned MIN_BIT     = 16,
  parameter int unsigned MAX_BIT     = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_i,
  input  logic restart_i,
  output logic tick_o,
  output logic baud_valid_o
);
  localparam int unsigned CNT_W = $clog2(2 * MAX_BIT + 2);
  localparam int unsigned TOT_W = $clog2(8 * MAX_BIT + 1);

  logic             fall;
  logic             lock;
  logic [TOT_W-1:0] span;

  abg_edge_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .rx_i  (rxd_i),
    .fall_o(fall)
  );

  abg_synch_meter #(
    .MIN_BIT(MIN_BIT),
    .MAX_BIT(MAX_BIT),
    .CNT_W  (CNT_W),
    .TOT_W  (TOT_W)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart_i),
    .fall_i   (fall),
    .lock_o   (lock),
    .span_o   (span)
  );

  abg_tick_gen #(
    .TOT_W(TOT_W)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart_i),
    .lock_i   (lock),
    .span_i   (span),
    .tick_o   (tick_o),
    .valid_o  (baud_valid_o)
  );

  // R1: reset leaves the block silent
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !baud_valid_o && !tick_o);
endmodule

// File: tb/autobaud_gen_bench.sv
module autobaud_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_BIT = 16;
  localparam int MAX_BIT = 128;
  localparam int LO = 2 * MIN_BIT;
  localparam int HI = 2 * MAX_BIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic restart = 1'b0;
  logic tick, valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  autobaud_gen #(
    .MIN_BIT(MIN_BIT),
    .MAX_BIT(MAX_BIT),
    .SYNC_STAGES(2)
  ) u_autobaud_gen (
    .clk         (clk),
    .rst         (rst),
    .rxd_i       (rxd),
    .restart_i   (restart),
    .tick_o      (tick),
    .baud_valid_o(valid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int     m_mode = 0;  // 0 hunting, 1 measuring, 2 locked
  int     h1 = 1, h2 = 1, h3 = 1;
  longint n = 0, last = 0, tot = 0, L = 0, M = 0, k = 0, nxt = 0, d = 0;
  int     edges = 0;
  bit     e_valid = 0, e_tick = 0;

  always @(posedge clk) begin : ref_model
    bit fall;
    fall = (h3 == 1 && h2 == 0);
    if (rst) begin
      m_mode = 0; e_valid = 0; e_tick = 0;
      h1 = 1; h2 = 1; h3 = 1;
    end else begin
      if (restart) begin
        m_mode = 0; e_valid = 0; e_tick = 0;
      end else begin
        e_tick = 0;
        case (m_mode)
          0: if (fall) begin m_mode = 1; last = n; edges = 1; tot = 0; end
          1: begin
            d = n - last;
            if (fall) begin
              if (d < LO || d > HI) m_mode = 0;
              else begin
                tot += d; edges++; last = n;
                if (edges == 5) begin
                  m_mode = 2; e_valid = 1; L = n; M = tot; k = 1;
                  nxt = L + (k * M) / 128;
                end
              end
            end else if (d > HI) m_mode = 0;
          end
          default: if (n == nxt) begin
            e_tick = 1; k++; nxt = L + (k * M) / 128;
          end
        endcase
      end
      h3 = h2; h2 = h1; h1 = int'(rxd);
    end
    n++;
  end

  always @(negedge clk) begin
    if (!done && !rst) begin
      chk(tick == e_tick, "R5", "tick vs model", longint'(tick), longint'(e_tick));
      chk(valid == e_valid, "R2", "valid vs model", longint'(valid), longint'(e_valid));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(1'b0, "R1", "watchdog expired", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic pulse_restart();
    restart = 1'b1; idle(1); restart = 1'b0;
  endtask

  // 0x55 framed: four (low b, high b +/- j) pairs, then bit7 low, then stop high
  task automatic send_synch(int b, int j, bit restart_at_lock);
    for (int i = 0; i < 4; i++) begin
      rxd = 1'b0; idle(b);
      rxd = 1'b1; idle(b + ((i % 2) != 0 ? -j : j));
    end
    rxd = 1'b0;
    if (restart_at_lock) begin
      idle(2); restart = 1'b1; idle(1); restart = 1'b0; idle(b - 3);
    end else idle(b);
    rxd = 1'b1; idle(b);
  endtask

  task automatic tick_window(int S, string req);
    int cnt = 0, gap = 0, gmin = 1000000, gmax = 0;
    bit seen = 0;
    repeat (S) begin
      @(negedge clk);
      gap++;
      if (tick) begin
        cnt++;
        if (seen) begin
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
        end
        seen = 1; gap = 0;
      end
    end
    chk(cnt == 128, req, "strobes per span", cnt, 128);
    chk(gmin >= S / 128 && gmax <= (S + 127) / 128, req, "strobe spacing min",
        gmin, S / 128);
  endtask

  initial begin
    idle(3);
    chk(valid == 1'b0, "R1", "valid in reset", valid, 0);
    chk(tick == 1'b0, "R1", "tick in reset", tick, 0);
    rst = 1'b0;
    idle(10);

    // R2: clean character, bit = 100 clocks, S = 800
    send_synch(100, 0, 0);
    chk(valid == 1'b1, "R2", "valid after synch", valid, 1);
    tick_window(800, "R5");

    // R6: line activity and a second character while locked
    for (int i = 0; i < 10; i++) begin rxd = ~rxd; idle(7 + i); end
    rxd = 1'b1; idle(5);
    send_synch(40, 0, 0);
    chk(valid == 1'b1, "R6", "valid held", valid, 1);
    tick_window(800, "R6");

    // R7 and R8: restart clears and silences
    pulse_restart();
    chk(valid == 1'b0, "R7", "valid after restart", valid, 0);
    begin
      int tc = 0;
      repeat (60) begin @(negedge clk); if (tick) tc++; end
      chk(tc == 0, "R8", "strobes while invalid", tc, 0);
    end

    // R5: uneven gaps, fractional period S = 296
    send_synch(37, 3, 0);
    chk(valid == 1'b1, "R5", "valid fractional", valid, 1);
    tick_window(296, "R5");
    tick_window(296, "R5");

    // R3: gaps too short
    pulse_restart();
    send_synch(10, 0, 0);
    idle(HI + 10);
    chk(valid == 1'b0, "R3", "short gaps rejected", valid, 0);

    // R4: gaps too long
    send_synch(140, 0, 0);
    idle(HI + 10);
    chk(valid == 1'b0, "R4", "long gaps time out", valid, 0);

    // R2 again after failures: S = 512, integer period
    send_synch(64, 0, 0);
    chk(valid == 1'b1, "R2", "relock after rejects", valid, 1);
    tick_window(512, "R5");

    // R7: restart on the lock edge wins
    pulse_restart();
    idle(5);
    send_synch(50, 0, 1);
    idle(20);
    chk(valid == 1'b0, "R7", "restart beats lock", valid, 0);
    begin
      int tc = 0;
      repeat (40) begin @(negedge clk); if (tick) tc++; end
      chk(tc == 0, "R8", "no strobes after cancelled lock", tc, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule